// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This engine stores one incoming frame at a time into memory buffers that software has handed over through a ring of receive descriptors. Frame bytes arrive on a byte stream with a valid/ready handshake and an end-of-frame marker. The engine folds every byte into a running CRC-32, optionally puts two zero bytes in front of the payload, and appends the four CRC bytes behind it. It then spreads the result over as many free buffers as needed, each holding at most a programmed number of bytes.

Every buffer it fills gets its descriptor written back with a length and with the free bit cleared. The descriptor that closes the frame also carries a last marker and two error flags. One marks a frame that was cut short at the truncation length. The other marks a frame longer than the length limit. A one-cycle event pulse follows every descriptor write-back: one pulse for a buffer that continues the frame, another for the buffer that ends it.

A receive-active flag gates everything. It is set by a kick while the descriptor under the ring pointer is free. After each frame it is recomputed from the descriptor the pointer has moved to. A frame that arrives while the flag is clear is consumed and thrown away.

Top module: `rxr_engine`

## Requirements
- R1: While rx_active is 0, a frame on the stream is accepted to its last byte with no memory write and no event, and rx_active stays 0.
- R2: The stored bytes are the frame data followed by its CRC-32, with the most significant byte first. The CRC is the reflected 0xEDB88320 polynomial with all-ones start and inverted result. The four CRC bytes count toward the stored size.
- R3: With shift16_en set, two zero bytes are stored at the start of the first buffer, ahead of the data, and the stored size grows by two.
- R4: When pad plus data plus CRC would exceed trunc_len, only the leading data bytes that fit are kept, the CRC still fills the last four stored bytes, the stored size equals trunc_len, and the last descriptor gets both the truncated flag (flag bit 0, word bit 16) and the length-error flag (flag bit 5, word bit 21).
- R5: A stored size above len_limit that needs no truncation sets only the length-error flag.
- R6: A descriptor is two words: flags in bits 31:16 and length in bits 15:0 at offset 0, and the buffer address at offset 4. Each buffer takes at most max_buf bytes. The descriptor's length field gets the byte count of its chunk, its free bit (flag bit 15, word bit 31) is cleared, and its wrap bit is kept.
- R7: If a descriptor reached in the middle of a frame has its free bit clear, it is left untouched, the rest of the frame is consumed without being stored, no frame event is raised, and rx_active ends at 0.
- R8: The descriptor that ends a frame gets the last flag (flag bit 11, word bit 27) together with the error flags, and ev_frame pulses once. Every earlier descriptor of the frame pulses ev_buf once. Each pulse comes in the cycle after that descriptor's write-back.
- R9: After a write-back, the ring pointer returns to ring_base if the descriptor's wrap bit (flag bit 13, word bit 29) is set. Otherwise it advances by 8.
- R10: rx_active is 0 after reset and after ring_init. ring_init also sets the pointer to ring_base. A kick while rx_active is 0 copies the free bit of the descriptor under the pointer into rx_active. After each stored frame, rx_active becomes the free bit of the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_init | input | 1 | Pulse: pointer to ring start, receive inactive |
| ring_base | input | ADDR_W | Byte address of the first descriptor |
| rx_kick | input | 1 | Pulse: re-examine the descriptor under the pointer |
| max_buf | input | 16 | Maximum bytes per buffer (at least 4) |
| len_limit | input | 16 | Stored sizes above this set the length-error flag |
| trunc_len | input | 16 | Largest stored size (at least 8) |
| shift16_en | input | 1 | Insert two leading zero bytes |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of the frame |
| s_ready | output | 1 | Stream byte accepted |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | ADDR_W | Byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rx_active | output | 1 | Receive-active flag |
| ev_buf | output | 1 | Pulse: a non-final buffer was completed |
| ev_frame | output | 1 | Pulse: a frame was completed |

## Verification
Results have fixed latencies:
- A kick updates rx_active at the second clock edge after the kick is sampled, one edge to issue the read and one to capture it.
- Each descriptor write lands at the edge that samples the request. The matching event pulse is high in the following cycle.
- After the final byte of the frame, the descriptor write and the probe of the next descriptor take a bounded number of cycles, about a dozen.

The bench drives stimulus on falling edges and samples outputs on falling edges. Whenever ev_frame is high it reads back the final descriptor, which must already hold the last flag at that point. Before comparing memory, event counts and rx_active, it leaves a margin of several cycles beyond the longest of these latencies.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int FLD_W     = 16;
  localparam int DESC_STEP = 8;
  localparam int FB_EMPTY  = 15;
  localparam int FB_WRAP   = 13;
  localparam int FB_LAST   = 11;
  localparam int FB_LENERR = 5;
  localparam int FB_TRUNC  = 0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DROP, ST_FETCH_A, ST_FETCH_B, ST_FETCH_C,
    ST_MOVE, ST_CLOSE_LAST, ST_SKIP, ST_PROBE, ST_PROBE_CAP
  } eng_state_e;

  typedef enum logic [1:0] {PH_PAD, PH_DATA, PH_FCS} byte_phase_e;
endpackage

// File: rtl/rxr_crc32.sv
module rxr_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);
  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr) begin
      crc_d = '1;
    end else if (en) begin
      crc_d = crc_q ^ {24'h0, din};
      for (int b = 0; b < 8; b++) begin
        crc_d = crc_d[0] ? ((crc_d >> 1) ^ 32'hEDB8_8320) : (crc_d >> 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_d;
  end

  assign fcs = ~crc_q;
endmodule

// File: rtl/rxr_size_track.sv
module rxr_size_track #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         store,
  input  logic         hit,
  input  logic [W-1:0] trunc_len,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         at_cap,
  output logic         truncated,
  output logic         len_err
);
  logic [W-1:0] count_q, count_d;
  logic         tr_q, tr_d;

  always_comb begin
    count_d = count_q;
    tr_d    = tr_q;
    if (clr) begin
      count_d = '0;
      tr_d    = 1'b0;
    end else begin
      if (store) count_d = count_q + W'(1);
      if (hit)   tr_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      tr_q    <= 1'b0;
    end else begin
      count_q <= count_d;
      tr_q    <= tr_d;
    end
  end

  assign count     = count_q;
  assign at_cap    = ({1'b0, count_q} + (W+1)'(4)) >= {1'b0, trunc_len};
  assign truncated = tr_q;
  assign len_err   = tr_q | (count_q > limit);

  // R4: the stored size never passes the truncation length
  a_r4_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= trunc_len);
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          adv,
  input  logic          wrap,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (init)     ptr_d = base;
    else if (adv) ptr_d = wrap ? base : (ptr_q + AW'(STEP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R9: a plain advance moves exactly one descriptor
  a_r9_plain_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap && !init) |=> (ptr_q - $past(ptr_q)) == AW'(STEP));
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_init,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              rx_kick,
  input  logic [15:0]       max_buf,
  input  logic [15:0]       len_limit,
  input  logic [15:0]       trunc_len,
  input  logic              shift16_en,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              rx_active,
  output logic              ev_buf,
  output logic              ev_frame
);
  localparam logic [FLD_W-1:0] MASK_EMPTY = FLD_W'(1) << FB_EMPTY;

  eng_state_e        state_q, state_d;
  byte_phase_e       phase_q, phase_d;
  logic              pad_q, pad_d;
  logic [1:0]        fidx_q, fidx_d;
  logic [FLD_W-1:0]  flags_q, flags_d;
  logic [ADDR_W-1:0] buf_q, buf_d;
  logic [FLD_W-1:0]  bcnt_q, bcnt_d;
  logic              active_q, active_d;
  logic              evb_q, evb_d, evf_q, evf_d;

  logic              crc_clr, crc_en;
  logic [31:0]       fcs;
  logic              sz_clr, sz_store, sz_hit;
  logic [FLD_W-1:0]  sz_count;
  logic              at_cap, truncated, len_err;
  logic              p_init, p_adv;
  logic [ADDR_W-1:0] ptr;

  logic [7:0]        cur_byte;
  logic              pend, keep, full;
  logic [ADDR_W-1:0] byte_addr;
  logic [FLD_W-1:0]  final_flags;

  rxr_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(s_data), .fcs(fcs)
  );

  rxr_size_track #(.W(FLD_W)) u_size (
    .clk(clk), .rst_n(rst_n), .clr(sz_clr), .store(sz_store), .hit(sz_hit),
    .trunc_len(trunc_len), .limit(len_limit), .count(sz_count),
    .at_cap(at_cap), .truncated(truncated), .len_err(len_err)
  );

  rxr_ring_ptr #(.AW(ADDR_W), .STEP(DESC_STEP)) u_ptr (
    .clk(clk), .rst_n(rst_n), .init(p_init), .adv(p_adv),
    .wrap(flags_q[FB_WRAP]), .base(ring_base), .ptr(ptr)
  );

  // byte source: pad zeros, stream data, then CRC most significant first
  always_comb begin
    unique case (phase_q)
      PH_PAD: begin
        cur_byte = 8'h00;
        pend     = 1'b1;
        keep     = 1'b1;
      end
      PH_DATA: begin
        cur_byte = s_data;
        pend     = s_valid;
        keep     = !at_cap;
      end
      default: begin
        unique case (fidx_q)
          2'd0:    cur_byte = fcs[31:24];
          2'd1:    cur_byte = fcs[23:16];
          2'd2:    cur_byte = fcs[15:8];
          default: cur_byte = fcs[7:0];
        endcase
        pend = 1'b1;
        keep = 1'b1;
      end
    endcase
  end

  assign full        = (bcnt_q == max_buf);
  assign byte_addr   = buf_q + ADDR_W'(bcnt_q);
  assign final_flags = (flags_q & ~MASK_EMPTY)
                     | (FLD_W'(1) << FB_LAST)
                     | (FLD_W'(len_err) << FB_LENERR)
                     | (FLD_W'(truncated) << FB_TRUNC);

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    pad_d    = pad_q;
    fidx_d   = fidx_q;
    flags_d  = flags_q;
    buf_d    = buf_q;
    bcnt_d   = bcnt_q;
    active_d = active_q;
    evb_d    = 1'b0;
    evf_d    = 1'b0;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = ptr;
    mem_be   = 4'h0;
    mem_wdata = 32'h0;
    s_ready  = 1'b0;
    crc_clr  = 1'b0;
    crc_en   = 1'b0;
    sz_clr   = 1'b0;
    sz_store = 1'b0;
    sz_hit   = 1'b0;
    p_init   = 1'b0;
    p_adv    = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (ring_init) begin
          p_init   = 1'b1;
          active_d = 1'b0;
        end else if (s_valid) begin
          if (active_q) begin
            state_d = ST_FETCH_A;
            phase_d = shift16_en ? PH_PAD : PH_DATA;
            pad_d   = 1'b0;
            fidx_d  = 2'd0;
            crc_clr = 1'b1;
            sz_clr  = 1'b1;
          end else begin
            state_d = ST_DROP;
          end
        end else if (rx_kick && !active_q) begin
          mem_req = 1'b1;
          state_d = ST_PROBE_CAP;
        end
      end
      ST_DROP: begin
        s_ready = 1'b1;
        if (s_valid && s_last) state_d = ST_IDLE;
      end
      ST_FETCH_A: begin
        mem_req = 1'b1;
        state_d = ST_FETCH_B;
      end
      ST_FETCH_B: begin
        flags_d  = mem_rdata[31:16];
        mem_req  = 1'b1;
        mem_addr = ptr + ADDR_W'(4);
        state_d  = ST_FETCH_C;
      end
      ST_FETCH_C: begin
        buf_d  = mem_rdata[ADDR_W-1:0];
        bcnt_d = '0;
        if (!flags_q[FB_EMPTY]) state_d = (phase_q == PH_FCS) ? ST_PROBE : ST_SKIP;
        else                    state_d = ST_MOVE;
      end
      ST_MOVE: begin
        if (pend) begin
          if (full) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_be    = 4'hF;
            mem_wdata = {flags_q & ~MASK_EMPTY, bcnt_q};
            evb_d     = 1'b1;
            p_adv     = 1'b1;
            state_d   = ST_FETCH_A;
          end else begin
            if (phase_q == PH_DATA) begin
              s_ready = 1'b1;
              crc_en  = 1'b1;
            end
            if (keep) begin
              mem_req   = 1'b1;
              mem_we    = 1'b1;
              mem_addr  = byte_addr;
              mem_be    = 4'b0001 << byte_addr[1:0];
              mem_wdata = {4{cur_byte}};
              bcnt_d    = bcnt_q + FLD_W'(1);
              sz_store  = 1'b1;
            end else begin
              sz_hit = 1'b1;
            end
            unique case (phase_q)
              PH_PAD: begin
                pad_d = 1'b1;
                if (pad_q) phase_d = PH_DATA;
              end
              PH_DATA: begin
                if (s_last) phase_d = PH_FCS;
              end
              default: begin
                fidx_d = fidx_q + 2'd1;
                if (fidx_q == 2'd3) state_d = ST_CLOSE_LAST;
              end
            endcase
          end
        end
      end
      ST_CLOSE_LAST: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 4'hF;
        mem_wdata = {final_flags, bcnt_q};
        evf_d     = 1'b1;
        p_adv     = 1'b1;
        state_d   = ST_PROBE;
      end
      ST_SKIP: begin
        s_ready = 1'b1;
        if (s_valid && s_last) state_d = ST_PROBE;
      end
      ST_PROBE: begin
        mem_req = 1'b1;
        state_d = ST_PROBE_CAP;
      end
      ST_PROBE_CAP: begin
        active_d = mem_rdata[16+FB_EMPTY];
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_DATA;
      pad_q    <= 1'b0;
      fidx_q   <= 2'd0;
      flags_q  <= '0;
      buf_q    <= '0;
      bcnt_q   <= '0;
      active_q <= 1'b0;
      evb_q    <= 1'b0;
      evf_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      pad_q    <= pad_d;
      fidx_q   <= fidx_d;
      flags_q  <= flags_d;
      buf_q    <= buf_d;
      bcnt_q   <= bcnt_d;
      active_q <= active_d;
      evb_q    <= evb_d;
      evf_q    <= evf_d;
    end
  end

  assign rx_active = active_q;
  assign ev_buf    = evb_q;
  assign ev_frame  = evf_q;

  // R1: a dropped frame touches no memory
  a_r1_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP) |-> !mem_req);

  // R6: descriptor write-backs never exceed the buffer size and release the slot
  a_r6_len_within_max: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be == 4'hF) |-> (mem_wdata[15:0] <= max_buf && !mem_wdata[31]));

  // R3: pad bytes are zero
  a_r3_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MOVE && phase_q == PH_PAD && mem_we && mem_be != 4'hF) |-> mem_wdata == 32'h0);

  // R7: a discarded remainder writes nothing
  a_r7_skip_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !mem_we);

  // R8: buffer and frame events never coincide
  a_r8_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_buf && ev_frame));

  // R10: rx_active only moves from idle or from a descriptor probe
  a_r10_active_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_active) |-> ($past(state_q) == ST_IDLE || $past(state_q) == ST_PROBE_CAP));
endmodule

// File: tb/sim_rxr_engine.sv
module sim_rxr_engine;
  localparam int CLK_P     = 10;
  localparam int MEM_WORDS = 512;
  localparam int BUF_BASE  = 32'h200;
  localparam int TRUNC     = 48;
  localparam int LIMIT     = 36;

  logic clk, rst_n;
  logic ring_init, rx_kick, shift16_en;
  logic [31:0] ring_base;
  logic [15:0] max_buf, len_limit, trunc_len;
  logic s_valid, s_last, s_ready;
  logic [7:0] s_data;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic rx_active, ev_buf, ev_frame;

  logic h_we;
  logic [31:0] h_addr, h_data;
  logic [31:0] mem [0:MEM_WORDS-1];

  int n_checks, n_errors;
  int buf_evs, frame_evs;
  logic exp_valid;
  logic [31:0] exp_last_addr, exp_last_word;

  rxr_engine u0 (
    .clk(clk), .rst_n(rst_n), .ring_init(ring_init), .ring_base(ring_base),
    .rx_kick(rx_kick), .max_buf(max_buf), .len_limit(len_limit),
    .trunc_len(trunc_len), .shift16_en(shift16_en), .s_valid(s_valid),
    .s_data(s_data), .s_last(s_last), .s_ready(s_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_active(rx_active),
    .ev_buf(ev_buf), .ev_frame(ev_frame)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (h_we) begin
      mem[h_addr[10:2]] <= h_data;
    end else if (mem_req) begin
      if (mem_we) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) mem[mem_addr[10:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[10:2]];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R8: when ev_frame is high the final descriptor is already in memory
  always @(negedge clk) begin
    if (rst_n && ev_buf) buf_evs++;
    if (rst_n && ev_frame) begin
      frame_evs++;
      if (exp_valid) chk("R8 final descriptor present at ev_frame", mem[exp_last_addr[10:2]], exp_last_word);
    end
  end

  function automatic logic [7:0] data_byte(input int k, input int len);
    return 8'((k*13 + len*5 + 1) & 255);
  endfunction

  function automatic logic [31:0] crc_of(input int len);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < len; k++) begin
      c = c ^ {24'h0, data_byte(k, len)};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [7:0] rd_b(input int a);
    logic [31:0] w;
    w = mem[a >> 2];
    return w[8*(a & 3) +: 8];
  endfunction

  task automatic host_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    h_we = 1'b1; h_addr = 32'(a); h_data = d;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic pulse_init();
    @(negedge clk); ring_init = 1'b1;
    @(negedge clk); ring_init = 1'b0;
  endtask

  task automatic pulse_kick();
    @(negedge clk); rx_kick = 1'b1;
    @(negedge clk); rx_kick = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic setup_ring(input int wrap_idx, input int hole_idx, input bit kick);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] f;
      f = 16'h0;
      if (i != hole_idx) f[15] = 1'b1;
      if (i == wrap_idx) f[13] = 1'b1;
      host_wr(i*8, {f, 16'h0});
      host_wr(i*8 + 4, 32'(BUF_BASE + i*64));
    end
    pulse_init();
    if (kick) pulse_kick();
  endtask

  task automatic send_frame(input int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = data_byte(k, len); s_last = (k == len-1);
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  // expected stored byte stream for a frame
  function automatic logic [7:0] exp_byte(input int idx, input int len, input int pad, input int keep);
    logic [31:0] c;
    if (idx < pad) return 8'h00;
    if (idx < pad + keep) return data_byte(idx - pad, len);
    c = crc_of(len);
    return c[31 - 8*(idx - pad - keep) -: 8];
  endfunction

  // full frame in a fresh ring with wrap on the last slot
  task automatic run_sweep_frame(input int len, input int mb, input int sh);
    int pad, keep, sz, n, b0, f0, bad, tr, lg;
    pad  = sh ? 2 : 0;
    keep = (len < TRUNC - 4 - pad) ? len : TRUNC - 4 - pad;
    sz   = pad + keep + 4;
    n    = (sz + mb - 1) / mb;
    tr   = (len > keep) ? 1 : 0;
    lg   = (tr == 1 || sz > LIMIT) ? 1 : 0;
    max_buf = 16'(mb); shift16_en = sh[0];
    setup_ring(7, -1, 1'b1);
    exp_last_addr = 32'((n-1)*8);
    exp_last_word = {(n-1 == 7 ? 16'h2000 : 16'h0) | 16'h0800 | (lg ? 16'h0020 : 16'h0) | (tr ? 16'h0001 : 16'h0),
                     16'(sz - (n-1)*mb)};
    exp_valid = 1'b1;
    b0 = buf_evs; f0 = frame_evs;
    send_frame(len);
    exp_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [15:0] f;
      f = (i == 7) ? 16'h2000 : 16'h0;
      if (i == n-1) chk($sformatf("R4/R5/R6/R8 last desc len=%0d mb=%0d sh=%0d", len, mb, sh), mem[i*2], exp_last_word);
      else          chk($sformatf("R6 mid desc %0d len=%0d mb=%0d sh=%0d", i, len, mb, sh), mem[i*2], {f, 16'(mb)});
    end
    bad = 0;
    for (int j = 0; j < sz; j++)
      if (rd_b(BUF_BASE + (j / mb)*64 + (j % mb)) !== exp_byte(j, len, pad, keep)) bad++;
    chk($sformatf("R2/R3 stored bytes len=%0d mb=%0d sh=%0d", len, mb, sh), 32'(bad), 32'd0);
    chk($sformatf("R8 buffer events len=%0d", len), 32'(buf_evs - b0), 32'(n-1));
    chk($sformatf("R8 frame events len=%0d", len), 32'(frame_evs - f0), 32'd1);
    chk($sformatf("R10 active after frame len=%0d", len), {31'h0, rx_active}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin : main
    int b0, f0, bad;
    n_checks = 0; n_errors = 0; buf_evs = 0; frame_evs = 0;
    exp_valid = 1'b0; exp_last_addr = '0; exp_last_word = '0;
    rst_n = 1'b0; ring_init = 1'b0; rx_kick = 1'b0; ring_base = 32'h0;
    max_buf = 16'd16; len_limit = 16'(LIMIT); trunc_len = 16'(TRUNC);
    shift16_en = 1'b0; s_valid = 1'b0; s_data = 8'h0; s_last = 1'b0;
    h_we = 1'b0; h_addr = '0; h_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rx_active after reset", {31'h0, rx_active}, 32'd0);
    chk("R8 no events after reset", {30'h0, ev_buf, ev_frame}, 32'd0);
    chk("R1 s_ready low when idle", {31'h0, s_ready}, 32'd0);

    // R1: inactive ring drops the frame
    setup_ring(7, -1, 1'b0);
    b0 = buf_evs; f0 = frame_evs;
    send_frame(10);
    chk("R1 descriptor untouched while inactive", mem[0], 32'h8000_0000);
    chk("R1 no events while inactive", 32'((buf_evs - b0) + (frame_evs - f0)), 32'd0);
    chk("R1 rx_active stays low", {31'h0, rx_active}, 32'd0);
    pulse_kick();
    chk("R10 kick on free descriptor sets active", {31'h0, rx_active}, 32'd1);

    // sweep: buffer size, pad option, frame length
    for (int mb = 8; mb <= 16; mb += 8)
      for (int sh = 0; sh < 2; sh++)
        for (int len = 1; len <= 52; len++)
          run_sweep_frame(len, mb, sh);

    // R7: occupied descriptor in the middle of a frame
    max_buf = 16'd8; shift16_en = 1'b0;
    setup_ring(7, 1, 1'b1);
    b0 = buf_evs; f0 = frame_evs;
    send_frame(20);
    chk("R7 first buffer written back", mem[0], 32'h0000_0008);
    chk("R7 occupied descriptor untouched", mem[2], 32'h0000_0000);
    chk("R7 no frame event", 32'(frame_evs - f0), 32'd0);
    chk("R7 one buffer event", 32'(buf_evs - b0), 32'd1);
    chk("R7 rx_active low after discard", {31'h0, rx_active}, 32'd0);

    // R9: wrap back to ring start
    max_buf = 16'd16;
    setup_ring(1, -1, 1'b1);
    send_frame(4);
    chk("R9 frame A in slot 0", mem[0], 32'h0800_0008);
    send_frame(4);
    chk("R9 frame B in wrap slot", mem[2], 32'h2800_0008);
    chk("R9 R10 pointer back at occupied slot 0", {31'h0, rx_active}, 32'd0);
    host_wr(0, 32'h8000_0000);
    pulse_kick();
    chk("R10 kick after slot freed", {31'h0, rx_active}, 32'd1);
    send_frame(6);
    chk("R9 frame C reuses slot 0", mem[0], 32'h0800_000A);
    chk("R9 wrap slot not rewritten", mem[2], 32'h2800_0008);
    bad = 0;
    for (int j = 0; j < 10; j++)
      if (rd_b(BUF_BASE + j) !== exp_byte(j, 6, 0, 6)) bad++;
    chk("R2 R9 frame C bytes", 32'(bad), 32'd0);

    // R10: ring_init clears active
    pulse_init();
    chk("R10 ring_init clears active", {31'h0, rx_active}, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule